// File: doc/BRIEF.md
# Debug Communication Scan Register

This block is a test-data-register path placed behind an existing JTAG TAP controller. It lets an external debugger exchange 32-bit words with on-chip logic through a small bank of mailbox registers. Each scan moves a 38-bit frame through the block. Bit 37 selects a write or a read, bits 36:32 give a register address, and bits 31:0 carry data. The access the frame describes takes place on the clock edge on which the TAP's Update-DR strobe is high.

Two registers are visible to the debugger. A read-only handshake register at address 0x04 holds two flags. One flag says whether a word from the debugger is still waiting for the device. The other says whether the device has left a word for the debugger. A mailbox register at address 0x05 carries data in both directions. A read request is answered on the following scan: Capture-DR loads the answer into the data field, and it is then shifted out. The device side is a plain strobe port in the TCK domain. The device takes the incoming word with a consume strobe and supplies an outgoing word with a load strobe.

Top module: `dbg_comm_scan`

## Requirements
- R1: On every TCK edge with the shift strobe high, TDI enters frame bit 37, every bit moves one place toward bit 0, and TDO shows frame bit 0 (data is bits 31:0, address is bits 36:32, and the write flag is bit 37).
- R2: On a TCK edge with the capture strobe high, the frame's data field loads the pending read value and bits 37:32 load zero.
- R3: An Update-DR with write flag 1 and address 0x05 copies the data field into the device receive register and sets the receive-full flag (dev_rx_valid).
- R4: An Update-DR with write flag 0 and address 0x04 makes the pending read value {30 zeros, W in bit 1, R in bit 0}, where R is receive-full and W is transmit-full, both taken before that edge.
- R5: An Update-DR with write flag 0 and address 0x05 makes the pending read value the transmit register and clears W. The data field shifted in with the request has no effect.
- R6: A dev_tx_load pulse stores dev_tx_data in the transmit register and sets W (dev_tx_full). A load on the same edge as a debugger read of 0x05 leaves W set.
- R7: A dev_rx_take pulse clears R. A debugger write to 0x05 on the same edge leaves R set.
- R8: Writes to 0x04, and any access to an address other than 0x04 or 0x05, change no register and make the pending read value zero. A debugger write to 0x05 also makes the pending read value zero.
- R9: Without an Update-DR strobe, shifting or capturing changes neither the flags nor the receive register.
- R10: After reset, R, W, the receive register, the pending read value and the frame are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Capture-DR strobe from the TAP controller |
| shift_dr | input | 1 | Shift-DR strobe from the TAP controller |
| update_dr | input | 1 | Update-DR strobe from the TAP controller |
| tdo | output | 1 | Serial data out (frame bit 0) |
| dev_rx_data | output | 32 | Word last written by the debugger |
| dev_rx_valid | output | 1 | R flag: word not yet consumed by the device |
| dev_rx_take | input | 1 | Device consume strobe, clears R |
| dev_tx_data | input | 32 | Word the device offers to the debugger |
| dev_tx_load | input | 1 | Device load strobe, sets W |
| dev_tx_full | output | 1 | W flag: word waiting for the debugger |

## Verification
The bench first shifts a long pattern with no update. This separates correct bit order and the 38-cycle delay from any unwanted register change. It then runs complete write and read scans to both addresses, checking each read on the next capture. These scans show whether the address and direction decode is right and whether the answer is delayed by one scan. Read requests carry all-ones junk in the data field, writes go to the read-only address, and accesses go to unused addresses, so the bench can see whether ignored fields leak into state. Device strobes are placed on the same edge as the opposing debugger access to pin down the set-over-clear priority of both flags.

// File: rtl/dbg_comm_pkg.sv
package dbg_comm_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int FRAME_W = DATA_W + ADDR_W + 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(5);

  // Packed MSB first: wr is bit FRAME_W-1, data ends at bit 0.
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_WR_DATA,
    ACC_RD_DATA,
    ACC_RD_CTRL,
    ACC_IGNORE
  } acc_t;
endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter
  import dbg_comm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  output frame_t            frame_q,
  output logic              tdo
);
  frame_t frame_d;
  logic   frame_en;

  assign frame_en = capture | shift;

  always_comb begin
    frame_d = frame_q;
    if (capture) begin
      frame_d      = '0;
      frame_d.data = cap_data;
    end else if (shift) begin
      frame_d = frame_t'({tdi, frame_q[FRAME_W-1:1]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (frame_en) begin
      frame_q <= frame_d;
    end
  end

  assign tdo = frame_q[0];
endmodule

// File: rtl/dbg_frame_decode.sv
module dbg_frame_decode
  import dbg_comm_pkg::*;
(
  input  logic   update,
  input  frame_t frame,
  output acc_t   acc
);
  always_comb begin
    acc = ACC_NONE;
    if (update) begin
      if (frame.addr == ADDR_DATA) begin
        acc = frame.wr ? ACC_WR_DATA : ACC_RD_DATA;
      end else if (frame.addr == ADDR_CTRL && !frame.wr) begin
        acc = ACC_RD_CTRL;
      end else begin
        acc = ACC_IGNORE;
      end
    end
  end
endmodule

// File: rtl/dbg_comm_regs.sv
module dbg_comm_regs
  import dbg_comm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_take,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_din,
  output logic [DATA_W-1:0] rx_q,
  output logic              r_q,
  output logic              w_q,
  output logic [DATA_W-1:0] pend_q
);
  logic [DATA_W-1:0] tx_q;
  logic              r_d, w_d;
  logic              rx_en, pend_en;
  logic [DATA_W-1:0] pend_d;

  assign rx_en   = (acc == ACC_WR_DATA);
  assign pend_en = (acc != ACC_NONE);

  always_comb begin
    r_d = r_q;
    if (rx_take) r_d = 1'b0;
    if (rx_en)   r_d = 1'b1;

    w_d = w_q;
    if (acc == ACC_RD_DATA) w_d = 1'b0;
    if (tx_load)            w_d = 1'b1;

    case (acc)
      ACC_RD_CTRL: pend_d = {{(DATA_W-2){1'b0}}, w_q, r_q};
      ACC_RD_DATA: pend_d = tx_q;
      default:     pend_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q    <= 1'b0;
      w_q    <= 1'b0;
      rx_q   <= '0;
      tx_q   <= '0;
      pend_q <= '0;
    end else begin
      r_q <= r_d;
      w_q <= w_d;
      if (rx_en)   rx_q   <= wdata;
      if (tx_load) tx_q   <= tx_din;
      if (pend_en) pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/dbg_comm_scan.sv
module dbg_comm_scan
  import dbg_comm_pkg::*;
(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  output logic              tdo,
  output logic [DATA_W-1:0] dev_rx_data,
  output logic              dev_rx_valid,
  input  logic              dev_rx_take,
  input  logic [DATA_W-1:0] dev_tx_data,
  input  logic              dev_tx_load,
  output logic              dev_tx_full
);
  logic [1:0]        rst_q;
  logic              rst_n_int;
  frame_t            scan_q;
  acc_t              acc;
  logic [DATA_W-1:0] pend;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_q <= '0;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_int = rst_q[1];

  dbg_scan_shifter u_shift (
    .clk      (tck),
    .rst_n    (rst_n_int),
    .capture  (capture_dr),
    .shift    (shift_dr),
    .tdi      (tdi),
    .cap_data (pend),
    .frame_q  (scan_q),
    .tdo      (tdo)
  );

  dbg_frame_decode u_dec (
    .update (update_dr),
    .frame  (scan_q),
    .acc    (acc)
  );

  dbg_comm_regs u_regs (
    .clk     (tck),
    .rst_n   (rst_n_int),
    .acc     (acc),
    .wdata   (scan_q.data),
    .rx_take (dev_rx_take),
    .tx_load (dev_tx_load),
    .tx_din  (dev_tx_data),
    .rx_q    (dev_rx_data),
    .r_q     (dev_rx_valid),
    .w_q     (dev_tx_full),
    .pend_q  (pend)
  );
endmodule

// File: rtl/dbg_comm_scan_chk.sv
module dbg_comm_scan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        capture_dr,
  input logic        update_dr,
  input logic [37:0] frame,
  input logic        dev_rx_take,
  input logic        dev_tx_load,
  input logic        dev_rx_valid,
  input logic [31:0] dev_rx_data,
  input logic        dev_tx_full
);
  logic wr5, rd5;
  assign wr5 = update_dr && frame[37]  && frame[36:32] == 5'd5;
  assign rd5 = update_dr && !frame[37] && frame[36:32] == 5'd5;

  AST_CAPTURE_CLEARS_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    capture_dr |=> frame[37:32] == 6'd0); // R2
  AST_WRITE_FILLS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    wr5 |=> dev_rx_valid && dev_rx_data == $past(frame[31:0])); // R3
  AST_READ_EMPTIES_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (rd5 && !dev_tx_load) |=> !dev_tx_full); // R5
  AST_LOAD_FILLS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_load |=> dev_tx_full); // R6
  AST_TAKE_EMPTIES_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rx_take && !wr5) |=> !dev_rx_valid); // R7
  AST_NO_UPDATE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!update_dr && !dev_rx_take) |=> $stable(dev_rx_valid) && $stable(dev_rx_data)); // R9
endmodule

bind dbg_comm_scan dbg_comm_scan_chk u_chk (
  .clk          (tck),
  .rst_n        (rst_n_int),
  .capture_dr   (capture_dr),
  .update_dr    (update_dr),
  .frame        (scan_q),
  .dev_rx_take  (dev_rx_take),
  .dev_tx_load  (dev_tx_load),
  .dev_rx_valid (dev_rx_valid),
  .dev_rx_data  (dev_rx_data),
  .dev_tx_full  (dev_tx_full)
);

// File: tb/tb_dbg_comm_scan.sv
module tb_dbg_comm_scan;
  logic        tck = 1'b0;
  logic        trst_n;
  logic        tdi, capture_dr, shift_dr, update_dr;
  logic        tdo;
  logic [31:0] dev_rx_data;
  logic        dev_rx_valid, dev_rx_take;
  logic [31:0] dev_tx_data;
  logic        dev_tx_load, dev_tx_full;

  int    vectors = 0;
  int    errors  = 0;
  string cur_req = "R10";

  // behavioural reference state
  logic [37:0] m_sr;
  logic        m_r, m_w;
  logic [31:0] m_rx, m_tx, m_pend;

  always #10 tck = ~tck;

  dbg_comm_scan dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdo(tdo),
    .dev_rx_data(dev_rx_data), .dev_rx_valid(dev_rx_valid),
    .dev_rx_take(dev_rx_take), .dev_tx_data(dev_tx_data),
    .dev_tx_load(dev_tx_load), .dev_tx_full(dev_tx_full)
  );

  task automatic model_reset();
    m_sr = '0; m_r = 0; m_w = 0; m_rx = '0; m_tx = '0; m_pend = '0;
  endtask

  task automatic model_edge();
    logic [37:0] sr_n;
    logic        r_n, w_n;
    logic [31:0] rx_n, tx_n, pend_n;
    sr_n = m_sr; r_n = m_r; w_n = m_w; rx_n = m_rx; tx_n = m_tx; pend_n = m_pend;
    if (capture_dr)    sr_n = {6'd0, m_pend};
    else if (shift_dr) sr_n = {tdi, m_sr[37:1]};
    if (dev_rx_take) r_n = 0;
    if (update_dr) begin
      if (m_sr[37] && m_sr[36:32] == 5'd5) begin
        rx_n = m_sr[31:0]; r_n = 1; pend_n = 0;
      end else if (!m_sr[37] && m_sr[36:32] == 5'd4) begin
        pend_n = {30'd0, m_w, m_r};
      end else if (!m_sr[37] && m_sr[36:32] == 5'd5) begin
        pend_n = m_tx; w_n = 0;
      end else begin
        pend_n = 0;
      end
    end
    if (dev_tx_load) begin w_n = 1; tx_n = dev_tx_data; end
    m_sr = sr_n; m_r = r_n; m_w = w_n; m_rx = rx_n; m_tx = tx_n; m_pend = pend_n;
  endtask

  task automatic compare();
    vectors++;
    if (tdo !== m_sr[0] || dev_rx_valid !== m_r || dev_tx_full !== m_w ||
        dev_rx_data !== m_rx) begin
      errors++;
      $display("FAIL %s t=%0t actual tdo=%b R=%b W=%b rx=%h expected tdo=%b R=%b W=%b rx=%h",
               cur_req, $time, tdo, dev_rx_valid, dev_tx_full, dev_rx_data,
               m_sr[0], m_r, m_w, m_rx);
    end
  endtask

  task automatic step();
    @(posedge tck);
    if (trst_n) model_edge(); else model_reset();
    @(negedge tck);
    compare();
    capture_dr = 0; shift_dr = 0; update_dr = 0; dev_rx_take = 0; dev_tx_load = 0;
  endtask

  task automatic scan(input logic [37:0] f, input bit upd, input bit take_u, input bit load_u);
    capture_dr = 1; step();
    for (int i = 0; i < 38; i++) begin
      shift_dr = 1; tdi = f[i]; step();
    end
    if (upd) begin
      update_dr = 1; dev_rx_take = take_u; dev_tx_load = load_u; step();
    end
    step();
  endtask

  function automatic logic [37:0] fr(input bit wr, input logic [4:0] a, input logic [31:0] d);
    return {wr, a, d};
  endfunction

  initial begin
    trst_n = 0; tdi = 0; capture_dr = 0; shift_dr = 0; update_dr = 0;
    dev_rx_take = 0; dev_tx_load = 0; dev_tx_data = '0;
    model_reset();
    @(negedge tck);
    cur_req = "R10";
    repeat (3) step();
    trst_n = 1;
    repeat (4) step();
    scan(fr(0, 5'd9, 32'h0), 0, 0, 0);           // empty capture after reset

    cur_req = "R1";                               // bit order through the chain
    scan(38'h2A_9C3F_0E71, 0, 0, 0);
    for (int i = 0; i < 38; i++) begin shift_dr = 1; tdi = i[0] ^ i[2]; step(); end
    cur_req = "R9";                               // full frame, no update
    scan(fr(1, 5'd5, 32'hDEAD_BEEF), 0, 0, 0);

    cur_req = "R3";
    scan(fr(1, 5'd5, 32'hA5C3_1E7F), 1, 0, 0);
    cur_req = "R4";
    scan(fr(0, 5'd4, 32'hFFFF_FFFF), 1, 0, 0);
    cur_req = "R2";
    scan(fr(0, 5'd0, 32'h0), 0, 0, 0);            // shifts out ctrl = 1

    cur_req = "R7";
    dev_rx_take = 1; step();
    scan(fr(1, 5'd5, 32'h0BAD_F00D), 1, 1, 0);    // write wins over take

    cur_req = "R6";
    dev_tx_data = 32'h1234_5678; dev_tx_load = 1; step();
    dev_tx_data = 32'h0;
    scan(fr(0, 5'd4, 32'h0), 1, 0, 0);
    scan(fr(0, 5'd0, 32'h0), 0, 0, 0);            // ctrl = 3

    cur_req = "R5";
    scan(fr(0, 5'd5, 32'hFFFF_FFFF), 1, 0, 0);
    scan(fr(0, 5'd4, 32'h0), 1, 0, 0);            // shifts out tx word
    scan(fr(0, 5'd0, 32'h0), 0, 0, 0);            // ctrl shows W clear

    cur_req = "R6";
    dev_tx_data = 32'hCAFE_0001; dev_tx_load = 1; step();
    dev_tx_data = 32'hCAFE_0002;
    scan(fr(0, 5'd5, 32'h0), 1, 0, 1);            // load wins over read
    scan(fr(0, 5'd0, 32'h0), 0, 0, 0);

    cur_req = "R8";
    scan(fr(1, 5'd4, 32'h0000_0003), 1, 0, 0);
    scan(fr(1, 5'd31, 32'h5555_AAAA), 1, 0, 0);
    scan(fr(0, 5'd7, 32'h0), 1, 0, 0);
    scan(fr(0, 5'd0, 32'h0), 0, 0, 0);            // pending is zero
    scan(fr(0, 5'd5, 32'h0), 1, 0, 0);
    scan(fr(1, 5'd5, 32'h7777_7777), 1, 0, 0);    // write zeroes pending
    scan(fr(0, 5'd0, 32'h0), 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule